// File: doc/BRIEF.md
# Dual-Window Cartridge Bank Mapper

This block sits between an 8-bit CPU bus with 16-bit addresses and the memories on a cartridge. It translates CPU addresses into physical ROM and RAM addresses. The switchable ROM area is split into two 8 KiB windows: window A spans 0x4000–0x5FFF and window B spans 0x6000–0x7FFF. The external RAM area 0xA000–0xBFFF is split into two 4 KiB windows: the low half at 0xA000 and the high half at 0xB000. Each of the four windows has its own bank register.

CPU writes are decoded one kilobyte at a time using address bits [15:10], called the slot. A slot can hold a control register, or it can carry a RAM store. A store passes through the same decode as a control write. The RAM array sits outside the block. The mapper drives its address, write strobe and write data, and returns its read data to the CPU only while RAM access is enabled.

Top module: `cart_dual_window_mapper`

## Requirements
- R1: After reset, ROM window A selects bank 2 and window B selects bank 3. RAM access is off, the low RAM half selects bank 0, the high RAM half selects bank 1, and `slot_err` is 0.
- R2: A write to slot 0 with data 0x0A turns RAM access on. Data 0x00 turns it off. Any other data leaves it as it was.
- R3: A write to slot 1 loads the low RAM half's bank from the data byte. A write to slot 2 loads the high RAM half's bank.
- R4: Writes to slots 0x08–0x09 load the bank of ROM window A, and writes to slots 0x0C–0x0D load the bank of window B. `rom_addr` = bank × 8192 + addr[12:0], taken modulo the ROM size. Address bit 13 picks the window.
- R5: A write in 0xA000–0xBFFF (slots 0x28–0x2F) raises `ram_we` in the same cycle, but only while RAM access is on. `ram_wdata` equals the bus data.
- R6: While RAM access is off, reads in 0xA000–0xBFFF return 0xFF. While it is on, they return `ram_rdata`. Reads anywhere else return 0xFF.
- R7: `ram_addr` = bank × 4096 + addr[11:0], masked with (RAM size − 1). Address bit 12 picks the high half over the low half.
- R8: A write to any slot not listed in R2–R5 changes no bank register and no enable state. It sets `slot_err`, which stays set until reset.
- R9: A register write takes effect from the next cycle on. A store in the cycle right after a bank or enable write uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe for this cycle |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data returned to the CPU for the RAM area |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| slot_err | output | 1 | Sticky flag: a write hit an unused slot |

## Verification
The enable gate and a RAM store meet on back-to-back cycles: a write to slot 0 takes effect at one edge, and a store may come in the very next cycle. The same holds for a bank-select write followed at once by a store or read through that window. The bench places each store directly after the gate write or the bank write, with no idle cycle between them. It judges `ram_we`, `ram_addr` and `bus_rdata` in that cycle against the value that was just written, never against the value it replaced.

// File: rtl/cdwm_pkg.sv
package cdwm_pkg;

  typedef enum logic [2:0] {
    SL_NONE,
    SL_GATE,
    SL_RBANK_LO,
    SL_RBANK_HI,
    SL_ROM_A,
    SL_ROM_B,
    SL_STORE
  } slot_kind_e;

  localparam logic [7:0] GATE_ON  = 8'h0A;
  localparam logic [7:0] GATE_OFF = 8'h00;
  localparam logic [7:0] OPEN_BUS = 8'hFF;

  // Kilobyte slot (addr[15:10]) to function
  function automatic slot_kind_e classify(input logic [5:0] slot);
    slot_kind_e k;
    case (slot) inside
      6'h00:           k = SL_GATE;
      6'h01:           k = SL_RBANK_LO;
      6'h02:           k = SL_RBANK_HI;
      [6'h08:6'h09]:   k = SL_ROM_A;
      [6'h0C:6'h0D]:   k = SL_ROM_B;
      [6'h28:6'h2F]:   k = SL_STORE;
      default:         k = SL_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cdwm_rst_sync.sv
module cdwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cdwm_ctrl.sv
module cdwm_ctrl
  import cdwm_pkg::*;
#(
  parameter int ROM_BW = 4,
  parameter int RAM_BW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [5:0]             slot,
  input  logic [7:0]             wdata,
  output logic                   ram_on,
  output logic [1:0][ROM_BW-1:0] rom_bank,
  output logic [1:0][RAM_BW-1:0] ram_bank,
  output logic                   slot_err
);
  slot_kind_e        kind;
  logic              ld_gate, gate_d, gate_q;
  logic              ld_err, err_q;
  logic [1:0]        ld_rom, ld_ram;
  logic [ROM_BW-1:0] rom_d;
  logic [RAM_BW-1:0] ram_d;

  // Next-state and load enables
  always_comb begin
    kind      = classify(slot);
    ld_gate   = wr_en && (kind == SL_GATE) &&
                ((wdata == GATE_ON) || (wdata == GATE_OFF));
    gate_d    = (wdata == GATE_ON);
    ld_rom[0] = wr_en && (kind == SL_ROM_A);
    ld_rom[1] = wr_en && (kind == SL_ROM_B);
    ld_ram[0] = wr_en && (kind == SL_RBANK_LO);
    ld_ram[1] = wr_en && (kind == SL_RBANK_HI);
    rom_d     = wdata[ROM_BW-1:0];
    ram_d     = wdata[RAM_BW-1:0];
    ld_err    = wr_en && (kind == SL_NONE) && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (ld_gate) gate_q <= gate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (ld_err) err_q <= 1'b1;
  end

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic [ROM_BW-1:0] rom_q;
    logic [RAM_BW-1:0] ram_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rom_q <= ROM_BW'(w + 2);
      else if (ld_rom[w]) rom_q <= rom_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ram_q <= RAM_BW'(w);
      else if (ld_ram[w]) ram_q <= ram_d;
    end

    assign rom_bank[w] = rom_q;
    assign ram_bank[w] = ram_q;
  end

  assign ram_on   = gate_q;
  assign slot_err = err_q;
endmodule

// File: rtl/cdwm_xlate.sv
module cdwm_xlate
  import cdwm_pkg::*;
#(
  parameter int ROM_AW = 17,
  parameter int RAM_AW = 15,
  localparam int ROM_BW = ROM_AW - 13,
  localparam int RAM_BW = RAM_AW - 12
) (
  input  logic [15:0]            bus_addr,
  input  logic                   bus_wr,
  input  logic                   ram_on,
  input  logic [1:0][ROM_BW-1:0] rom_bank,
  input  logic [1:0][RAM_BW-1:0] ram_bank,
  input  logic [7:0]             ram_rdata,
  output logic [ROM_AW-1:0]      rom_addr,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic                   ram_we,
  output logic [7:0]             bus_rdata
);
  logic in_ram;

  always_comb begin
    in_ram    = (bus_addr[15:13] == 3'b101);
    // bank fields are already truncated, which wraps to the memory size
    rom_addr  = {rom_bank[bus_addr[13]], bus_addr[12:0]};
    ram_addr  = {ram_bank[bus_addr[12]], bus_addr[11:0]};
    ram_we    = bus_wr && in_ram && ram_on;
    bus_rdata = (in_ram && ram_on) ? ram_rdata : OPEN_BUS;
  end
endmodule

// File: rtl/cart_dual_window_mapper.sv
module cart_dual_window_mapper #(
  parameter int ROM_AW = 17,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              slot_err
);
  localparam int ROM_BW = ROM_AW - 13;
  localparam int RAM_BW = RAM_AW - 12;

  logic                   rst_sync_n;
  logic                   ram_on;
  logic [1:0][ROM_BW-1:0] rom_bank;
  logic [1:0][RAM_BW-1:0] ram_bank;

  cdwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdwm_ctrl #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_wr),
    .slot     (bus_addr[15:10]),
    .wdata    (bus_wdata),
    .ram_on   (ram_on),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .slot_err (slot_err)
  );

  cdwm_xlate #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_xlate (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .ram_on    (ram_on),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .bus_rdata (bus_rdata)
  );

  assign ram_wdata = bus_wdata;
endmodule

// File: rtl/cdwm_chk.sv
module cdwm_chk #(
  parameter int ROM_AW = 17,
  parameter int RAM_AW = 15,
  localparam int ROM_BW = ROM_AW - 13,
  localparam int RAM_BW = RAM_AW - 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_we,
  input logic              slot_err
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_STORE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> bus_wr && (bus_addr[15:13] == 3'b101) &&
               (ram_addr[11:0] == bus_addr[11:0]));  // R5

  AST_GATE_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(bus_wr && (bus_addr[15:10] == 6'h00) && (bus_wdata == 8'h00))
    |-> !ram_we && ((bus_addr[15:13] != 3'b101) || (bus_rdata == 8'hFF)));  // R2

  AST_ROM_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(bus_wr && (bus_addr[15:11] == 5'b00100)) &&
    (bus_addr[15:13] == 3'b010)
    |-> rom_addr[ROM_AW-1:13] == $past(bus_wdata[ROM_BW-1:0]));  // R4

  AST_RAM_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(bus_wr && (bus_addr[15:10] == 6'h01)) &&
    (bus_addr[15:12] == 4'hA)
    |-> ram_addr[RAM_AW-1:12] == $past(bus_wdata[RAM_BW-1:0]));  // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |=> slot_err);  // R8

  AST_RD_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:13] != 3'b101) |-> (bus_rdata == 8'hFF));  // R6
endmodule

bind cart_dual_window_mapper cdwm_chk #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rom_addr  (rom_addr),
  .ram_addr  (ram_addr),
  .ram_we    (ram_we),
  .slot_err  (slot_err)
);

// File: tb/test_cart_dual_window_mapper.sv
module test_cart_dual_window_mapper;
  localparam int ROM_AW    = 17;
  localparam int RAM_AW    = 15;
  localparam int ROM_BANKS = 1 << (ROM_AW - 13);
  localparam int RAM_BANKS = 1 << (RAM_AW - 12);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       bus_addr;
  logic              bus_wr;
  logic [7:0]        bus_wdata;
  logic [7:0]        bus_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata;
  logic              slot_err;

  int errs   = 0;
  int checks = 0;

  always #5 clk = ~clk;

  // RAM model: content is a function of the physical address
  assign ram_rdata = ram_addr[7:0] ^ 8'hA5;

  cart_dual_window_mapper #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) i_cart_dual_window_mapper (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .slot_err  (slot_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = w;
    bus_wdata = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Observe all mapper state through the ports
  task automatic expect_state(input string req, input int ba, input int bb, input bit on,
                              input int lo, input int hi, input bit err);
    int ea;
    cyc(16'h4123, 1'b0, 8'h00);
    chk({req, " romA"}, 32'(rom_addr), 32'(((ba % ROM_BANKS) << 13) | 'h123));
    cyc(16'h6123, 1'b0, 8'h00);
    chk({req, " romB"}, 32'(rom_addr), 32'(((bb % ROM_BANKS) << 13) | 'h123));
    ea = ((lo % RAM_BANKS) << 12) | 'h456;
    cyc(16'hA456, 1'b0, 8'h00);
    chk({req, " ramLo"}, 32'(ram_addr), 32'(ea));
    chk({req, " rdLo"}, 32'(bus_rdata), on ? 32'((ea & 'hFF) ^ 'hA5) : 32'hFF);
    ea = ((hi % RAM_BANKS) << 12) | 'h456;
    cyc(16'hB456, 1'b0, 8'h00);
    chk({req, " ramHi"}, 32'(ram_addr), 32'(ea));
    chk({req, " rdHi"}, 32'(bus_rdata), on ? 32'((ea & 'hFF) ^ 'hA5) : 32'hFF);
    chk({req, " err"}, 32'(slot_err), 32'(err));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ea, eb, elo, ehi, eerr;
    int off, exp_a;
    rst_n     = 1'b0;
    bus_addr  = 16'h0000;
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;

    // R1: reset state
    do_reset();
    expect_state("R1", 2, 3, 1'b0, 0, 1, 1'b0);
    cyc(16'h0000, 1'b0, 8'h00);
    chk("R6 outside RAM area", 32'(bus_rdata), 32'hFF);

    // R8/R2/R3/R4: every slot, one write of 0x5C after a fresh reset
    for (int s = 0; s < 64; s++) begin
      do_reset();
      ea = 2; eb = 3; elo = 0; ehi = 1; eerr = 0;
      case (s)
        0, 'h28, 'h29, 'h2A, 'h2B, 'h2C, 'h2D, 'h2E, 'h2F: ;
        1:          elo = 'h5C;
        2:          ehi = 'h5C;
        8, 9:       ea = 'h5C;
        'hC, 'hD:   eb = 'h5C;
        default:    eerr = 1;
      endcase
      cyc(16'(s << 10) | 16'h0155, 1'b1, 8'h5C);
      chk("R5 no store while off", 32'(ram_we), 32'h0);
      expect_state(eerr ? "R8" : "R3/R4/R2", ea, eb, 1'b0, elo, ehi, eerr[0]);
    end

    // R4: ROM bank sweep with wrap, both windows, both slots of each
    do_reset();
    for (int b = 0; b < 2 * ROM_BANKS; b++) begin
      cyc((b % 2) ? 16'h2455 : 16'h2011, 1'b1, 8'(b));
      cyc((b % 2) ? 16'h3022 : 16'h3700, 1'b1, 8'(2 * ROM_BANKS - 1 - b));
      off = (b * 'h0101) & 'h1FFF;
      cyc(16'h4000 | 16'(off), 1'b0, 8'h00);
      chk("R4 window A", 32'(rom_addr), 32'(((b % ROM_BANKS) << 13) | off));
      cyc(16'h6000 | 16'(off), 1'b0, 8'h00);
      chk("R4 window B", 32'(rom_addr),
          32'((((2 * ROM_BANKS - 1 - b) % ROM_BANKS) << 13) | off));
    end

    // R7/R5/R6/R9: RAM bank sweep with wrap, store right after bank write
    cyc(16'h0000, 1'b1, 8'h0A);
    for (int b = 0; b < 2 * RAM_BANKS; b++) begin
      off = (b * 'h0111) & 'h0FFF;
      cyc(16'h0400 | 16'(b), 1'b1, 8'(b));
      cyc(16'h0800, 1'b1, 8'(b ^ 5));
      cyc(16'hA000 | 16'(off), 1'b1, 8'(b + 'h40));
      exp_a = ((b % RAM_BANKS) << 12) | off;
      chk("R9 store after bank write", 32'(ram_we), 32'h1);
      chk("R7 low half addr", 32'(ram_addr), 32'(exp_a));
      chk("R5 write data", 32'(ram_wdata), 32'((b + 'h40) & 'hFF));
      cyc(16'hB000 | 16'(off), 1'b1, 8'h00);
      exp_a = (((b ^ 5) % RAM_BANKS) << 12) | off;
      chk("R7 high half addr", 32'(ram_addr), 32'(exp_a));
      cyc(16'hB000 | 16'(off), 1'b0, 8'h00);
      chk("R6 read enabled", 32'(bus_rdata), 32'((exp_a & 'hFF) ^ 'hA5));
      chk("R5 no store on read", 32'(ram_we), 32'h0);
    end

    // R2: gate values and back-to-back gate/store
    cyc(16'h0000, 1'b1, 8'h55);
    cyc(16'hA010, 1'b1, 8'h77);
    chk("R2 other value keeps on", 32'(ram_we), 32'h1);
    cyc(16'h0000, 1'b1, 8'h00);
    cyc(16'hA010, 1'b1, 8'h77);
    chk("R2 store right after off", 32'(ram_we), 32'h0);
    cyc(16'hB010, 1'b0, 8'h00);
    chk("R6 read while off", 32'(bus_rdata), 32'hFF);
    cyc(16'h03FF, 1'b1, 8'hFF);
    cyc(16'hA010, 1'b1, 8'h77);
    chk("R2 other value keeps off", 32'(ram_we), 32'h0);
    cyc(16'h0000, 1'b1, 8'h0A);
    cyc(16'hBFFF, 1'b1, 8'h12);
    chk("R9 store right after on", 32'(ram_we), 32'h1);
    cyc(16'h0400, 1'b1, 8'h06);
    cyc(16'hA020, 1'b0, 8'h00);
    chk("R9 read right after bank write", 32'(ram_addr), 32'((6 << 12) | 'h020));
    cyc(16'h4000, 1'b1, 8'h0A);
    chk("R5 no store outside RAM", 32'(ram_we), 32'h0);
    cyc(16'h0000, 1'b0, 8'h00);
    chk("R8 flag after ROM-area write", 32'(slot_err), 32'h1);

    finish_run();
  end
endmodule